// File: doc/BRIEF.md
# Biphase-Mark Subframe Line Encoder

This block takes 32-bit audio subframes that have already been assembled elsewhere and drives them onto one serial line in biphase-mark form. It is clocked by the audio master clock. A ratio select sets how many master clocks make up one biphase half-bit, so the line toggles only on master-clock edges and an external flip-flop on the same clock can retime it. The four low bits of each subframe select a preamble. The encoder sends that preamble as a fixed eight-half-bit violation pattern, then sends bits 4 to 31 in biphase-mark code, lowest bit first.

Subframes arrive on a valid/ready stream. The encoder raises `s_ready` for exactly one cycle per subframe, at the half-bit tick that sends the last half-bit of the current subframe. A transfer takes place only in a cycle where `s_valid` and `s_ready` are both high. The source may hold `s_valid` high with stable data for as long as it likes; nothing is taken until `s_ready` comes. If `s_valid` is low when `s_ready` is high, the slot is not lost. The encoder fills it with a zero-audio subframe that carries the preamble the frame sequence needs, and it pulses `underflow`. The subframes that follow then go out back to back, with no idle half-bits between them.

Top module: `spdif_bmc_encoder`

## Requirements
- R1: While `rst_n` is low, `line_out` and `underflow` are low. While `enable` is low, `line_out`, `s_ready` and `underflow` are low from the first clock edge that samples it.
- R2: One half-bit lasts 1, 2 or 4 master clocks for `ratio_sel` 0, 1 or 2 (that is, 128x, 256x or 512x the sample rate). Code 3 behaves like 2. After `enable` rises, the first `s_ready` comes in the N-th cycle, where N is the half-bit length.
- R3: `s_data[3:0]` selects the preamble: 4'h1 gives the block-start pattern 11101000, 4'h2 gives the left pattern 11100010, and any other value gives the right pattern 11100100. Each pattern is sent leftmost half-bit first. The pattern is given for a line that is low just before it.
- R4: When the line is high just before a preamble, every half-bit of that preamble is inverted.
- R5: Bits 4 to 31 follow the preamble, bit 4 first. Each bit cell flips the line at its start, and a 1 flips it again at mid-cell.
- R6: `s_ready` is high for one cycle per subframe, 64 half-bits after the previous one. The first half-bit of the new subframe directly follows the last half-bit of the current one.
- R7: A subframe is taken only when `s_valid` and `s_ready` are both high. Held data is taken exactly once, in order.
- R8: When `s_ready` is high with `s_valid` low, a subframe with all payload bits zero is sent in that slot, and `underflow` is high for exactly the following cycle.
- R9: A filler subframe uses the right pattern after a block-start or left subframe. After a right subframe it uses the block-start pattern if `FRAMES_PER_BLOCK` frames have been sent since the last block start, and the left pattern otherwise.
- R10: While enabled, `line_out` changes only at a half-bit tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Audio master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run control; when low the line is held low and the sequence restarts |
| ratio_sel | input | 2 | Master clocks per half-bit: 0=1, 1=2, 2 or 3=4 |
| s_valid | input | 1 | Subframe stream valid |
| s_data | input | 32 | Subframe: [3:0] preamble code, [31:4] payload |
| s_ready | output | 1 | Subframe stream ready, one cycle per subframe |
| line_out | output | 1 | Biphase-mark serial line |
| underflow | output | 1 | One-cycle pulse when a slot was filled with zero audio |

## Verification
Let N be the half-bit length. If a subframe is taken at edge L, its half-bit j is visible from edge L+N·(j+1) up to the next N−1 edges, and `underflow` for that slot is visible just after edge L. The bench records the line, the stream signals and the flag once per cycle, sampled between edges. It then checks every cycle of every half-bit against these offsets, using a model that is built only from the patterns and coding rules. It also checks that the distance between ready pulses is exactly 64·N and that the first pulse lands N−1 cycles after enable is first seen.

// File: rtl/spdif_bmc_pkg.sv
package spdif_bmc_pkg;

  localparam int unsigned SUBFRAME_W = 32;
  localparam int unsigned CODE_W     = 4;
  localparam int unsigned PAYLOAD_W  = SUBFRAME_W - CODE_W;
  localparam int unsigned PRE_HB     = 2 * CODE_W;

  typedef enum logic [1:0] {
    KIND_BLOCK = 2'd0,
    KIND_LEFT  = 2'd1,
    KIND_RIGHT = 2'd2
  } pre_kind_e;

  function automatic pre_kind_e decode_kind(input logic [CODE_W-1:0] code);
    case (code)
      4'h1:    return KIND_BLOCK;
      4'h2:    return KIND_LEFT;
      default: return KIND_RIGHT;
    endcase
  endfunction

  // Half-bit levels for a line that was low before the preamble, leftmost first.
  function automatic logic [PRE_HB-1:0] kind_pattern(input pre_kind_e k);
    case (k)
      KIND_BLOCK: return 8'b1110_1000;
      KIND_LEFT:  return 8'b1110_0010;
      default:    return 8'b1110_0100;
    endcase
  endfunction

endpackage

// File: rtl/spdif_halfbit_tick.sv
module spdif_halfbit_tick #(
  parameter int unsigned DIV_LOG2_MAX = 2,
  parameter int unsigned SEL_W        = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [SEL_W-1:0] ratio_sel,
  output logic             tick
);
  localparam int unsigned CNT_W = (DIV_LOG2_MAX > 0) ? DIV_LOG2_MAX : 1;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;

  always_comb begin
    if (32'(ratio_sel) >= DIV_LOG2_MAX) lim = '1;
    else                                lim = CNT_W'((32'd1 << ratio_sel) - 32'd1);
  end

  assign tick = enable && (cnt == lim);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!enable) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && lim != '0 && $stable(ratio_sel)) |=> !tick); // R2

endmodule

// File: rtl/spdif_preamble_tracker.sv
module spdif_preamble_tracker
  import spdif_bmc_pkg::*;
#(
  parameter int unsigned FRAMES_PER_BLOCK = 192
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      enable,
  input  logic      load,
  input  logic      fill,
  input  pre_kind_e in_kind,
  output pre_kind_e use_kind
);
  localparam int unsigned FIDX_W = (FRAMES_PER_BLOCK > 1) ? $clog2(FRAMES_PER_BLOCK) : 1;
  localparam logic [FIDX_W-1:0] FIDX_LAST = FIDX_W'(FRAMES_PER_BLOCK - 1);

  pre_kind_e         last_kind;
  logic [FIDX_W-1:0] fidx;
  pre_kind_e         predicted;

  always_comb begin
    if (last_kind != KIND_RIGHT) predicted = KIND_RIGHT;
    else if (fidx == FIDX_LAST)  predicted = KIND_BLOCK;
    else                         predicted = KIND_LEFT;
  end

  assign use_kind = fill ? predicted : in_kind;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_kind <= KIND_RIGHT;
      fidx      <= FIDX_LAST;
    end else if (!enable) begin
      last_kind <= KIND_RIGHT;
      fidx      <= FIDX_LAST;
    end else if (load) begin
      last_kind <= use_kind;
      case (use_kind)
        KIND_BLOCK: fidx <= '0;
        KIND_LEFT:  fidx <= (fidx == FIDX_LAST) ? '0 : fidx + 1'b1;
        default:    fidx <= fidx;
      endcase
    end
  end

  AST_FILL_AFTER_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && load && use_kind != KIND_RIGHT) |=> (!(load && fill) || use_kind == KIND_RIGHT)); // R9

endmodule

// File: rtl/spdif_bmc_serializer.sv
module spdif_bmc_serializer
  import spdif_bmc_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enable,
  input  logic                 tick,
  input  logic [PAYLOAD_W-1:0] load_payload,
  input  pre_kind_e            load_kind,
  output logic                 need_load,
  output logic                 line
);
  localparam int unsigned HALF_BITS = 2 * (PAYLOAD_W + CODE_W);
  localparam int unsigned IDX_W     = $clog2(HALF_BITS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(HALF_BITS - 1);
  localparam logic [IDX_W-1:0] IDX_PRE  = IDX_W'(PRE_HB);
  localparam int unsigned PAT_W     = $clog2(PRE_HB);

  logic                 primed;
  logic [IDX_W-1:0]     idx;
  logic [PRE_HB-1:0]    pat;
  logic [PAYLOAD_W-1:0] shreg;
  logic                 inv_q;
  logic                 line_nxt;
  logic                 in_pre;

  assign in_pre    = (idx < IDX_PRE);
  assign need_load = enable && tick && (!primed || idx == IDX_LAST);

  always_comb begin
    if (in_pre)
      line_nxt = pat[PAT_W'(IDX_PRE - 1'b1 - idx)] ^ ((idx == '0) ? line : inv_q);
    else if (!idx[0])
      line_nxt = !line;
    else
      line_nxt = shreg[0] ? !line : line;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      primed <= 1'b0; idx <= '0; pat <= '0; shreg <= '0; inv_q <= 1'b0; line <= 1'b0;
    end else if (!enable) begin
      primed <= 1'b0; idx <= '0; pat <= '0; shreg <= '0; inv_q <= 1'b0; line <= 1'b0;
    end else if (tick) begin
      if (primed) begin
        line <= line_nxt;
        if (idx == '0) inv_q <= line;
        if (!in_pre && idx[0]) shreg <= shreg >> 1;
        idx <= (idx == IDX_LAST) ? '0 : idx + 1'b1;
      end
      if (need_load) begin
        pat    <= kind_pattern(load_kind);
        shreg  <= load_payload;
        primed <= 1'b1;
      end
    end
  end

  AST_CELL_FLIP: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && tick && primed && !in_pre && !idx[0]) |=> (line != $past(line))); // R5

endmodule

// File: rtl/spdif_bmc_encoder.sv
module spdif_bmc_encoder
  import spdif_bmc_pkg::*;
#(
  parameter int unsigned FRAMES_PER_BLOCK = 192,
  parameter int unsigned DIV_LOG2_MAX     = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        enable,
  input  logic [1:0]  ratio_sel,
  input  logic        s_valid,
  input  logic [31:0] s_data,
  output logic        s_ready,
  output logic        line_out,
  output logic        underflow
);
  logic                 tick;
  logic                 need_load;
  logic                 fill;
  logic [PAYLOAD_W-1:0] payload;
  pre_kind_e            use_kind;

  spdif_halfbit_tick #(.DIV_LOG2_MAX(DIV_LOG2_MAX), .SEL_W(2)) u_tick (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ratio_sel(ratio_sel), .tick(tick)
  );

  assign s_ready = need_load;
  assign fill    = need_load && !s_valid;
  assign payload = fill ? '0 : s_data[SUBFRAME_W-1:CODE_W];

  spdif_preamble_tracker #(.FRAMES_PER_BLOCK(FRAMES_PER_BLOCK)) u_track (
    .clk(clk), .rst_n(rst_n), .enable(enable), .load(need_load), .fill(fill),
    .in_kind(decode_kind(s_data[CODE_W-1:0])), .use_kind(use_kind)
  );

  spdif_bmc_serializer u_ser (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick),
    .load_payload(payload), .load_kind(use_kind),
    .need_load(need_load), .line(line_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       underflow <= 1'b0;
    else if (!enable) underflow <= 1'b0;
    else              underflow <= fill;
  end

  AST_DISABLED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!line_out && !underflow)); // R1
  AST_QUIET_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !tick) |=> $stable(line_out)); // R10
  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    s_ready |=> !s_ready); // R6
  AST_UF_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    underflow |=> !underflow); // R8
  AST_TAKE_NO_UF: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ready && s_valid && enable) |=> !underflow); // R7

endmodule

// File: tb/spdif_bmc_encoder_tb.sv
module spdif_bmc_encoder_tb;

  localparam int FR    = 4;
  localparam int LOGSZ = 8192;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enable = 1'b0;
  logic [1:0]  ratio_sel = 2'd0;
  logic        s_valid = 1'b0;
  logic [31:0] s_data = 32'd0;
  logic        s_ready, line_out, underflow;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  spdif_bmc_encoder #(.FRAMES_PER_BLOCK(FR)) u_dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .ratio_sel(ratio_sel),
    .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
    .line_out(line_out), .underflow(underflow)
  );

  // source queue: stall entries give up one slot with valid low
  logic [31:0] src   [0:31];
  logic        stall [0:31];
  int  src_n   = 0;
  int  src_pos = 0;
  logic hs_seen = 1'b0;

  logic        line_log [0:LOGSZ-1];
  logic        rdy_log  [0:LOGSZ-1];
  logic        vld_log  [0:LOGSZ-1];
  logic        uf_log   [0:LOGSZ-1];
  logic [31:0] dat_log  [0:LOGSZ-1];
  int cyc = 0;

  always @(negedge clk) begin
    if (hs_seen) begin src_pos++; hs_seen = 1'b0; end
    s_valid = (src_pos < src_n) && !stall[src_pos];
    s_data  = (src_pos < src_n) ? src[src_pos] : 32'hDEAD_BEEF;
    #1;
    if (cyc < LOGSZ) begin
      line_log[cyc] = line_out; rdy_log[cyc] = s_ready; vld_log[cyc] = s_valid;
      uf_log[cyc] = underflow;  dat_log[cyc] = s_data;
    end
    hs_seen = s_ready && (src_pos < src_n) && (s_valid || stall[src_pos]);
    cyc++;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int kind_of(input logic [3:0] c);
    if (c == 4'h1) return 0;
    if (c == 4'h2) return 1;
    return 2;
  endfunction

  function automatic logic [63:0] levels(input logic [31:0] w, input int kind, input logic prev);
    logic [7:0] p;
    logic [63:0] e;
    logic l;
    p = (kind == 0) ? 8'b11101000 : (kind == 1) ? 8'b11100010 : 8'b11100100;
    e = '0;
    for (int j = 0; j < 8; j++) e[j] = p[7-j] ^ prev;
    l = e[7];
    for (int b = 0; b < 28; b++) begin
      l = ~l; e[8+2*b] = l;
      if (w[4+b]) l = ~l;
      e[9+2*b] = l;
    end
    return e;
  endfunction

  task automatic clear_src();
    for (int i = 0; i < 32; i++) begin src[i] = 32'd0; stall[i] = 1'b0; end
    src_n = 0;
  endtask

  task automatic add(input logic [31:0] w, input bit st);
    src[src_n] = w; stall[src_n] = st; src_n++;
  endtask

  // Enable, run len cycles, disable; return the log index where enable was first seen.
  task automatic run(input logic [1:0] sel, input int len, output int s);
    @(negedge clk);
    enable = 1'b0; rst_n = 1'b1; ratio_sel = sel;
    src_pos = 0; hs_seen = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b1; s = cyc;
    repeat (len) @(negedge clk);
    enable = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic check_stream(input int s, input int e_end, input int n, input string tag,
                              output int takes, output int inv_seen, output int b_fills);
    logic prev;
    int last_k, fidx, lastk;
    bit first;
    prev = 1'b0; last_k = 2; fidx = FR - 1; lastk = -1; first = 1'b1;
    takes = 0; inv_seen = 0; b_fills = 0;
    for (int k = s; k < e_end; k++) begin
      if (rdy_log[k]) begin
        logic [31:0] w;
        logic [63:0] e;
        int kind, bad_i, bad_j, expk;
        bit vld;
        expk = first ? s + n - 1 : lastk + 64 * n;
        chk(k == expk, first ? "R2" : "R6", {tag, " ready cycle"}, k - s, expk - s);
        first = 1'b0; lastk = k;
        vld = vld_log[k];
        if (vld) begin w = dat_log[k]; kind = kind_of(w[3:0]); takes++; end
        else begin
          w = 32'd0;
          kind = (last_k != 2) ? 2 : (fidx == FR - 1) ? 0 : 1;
          if (kind == 0) b_fills++;
        end
        if (k + 2 < e_end) begin
          chk(uf_log[k+1] == !vld, "R8", {tag, " underflow pulse"}, int'(uf_log[k+1]), int'(!vld));
          chk(uf_log[k+2] == 1'b0, "R8", {tag, " underflow width"}, int'(uf_log[k+2]), 0);
        end
        e = levels(w, kind, prev);
        if (prev) inv_seen++;
        bad_i = -1; bad_j = 0;
        for (int j = 0; j < 64; j++)
          for (int m = 1; m <= n; m++) begin
            int i;
            i = k + n * (j + 1) + m;
            if (i < e_end && bad_i < 0 && line_log[i] != e[j]) begin bad_i = i; bad_j = j; end
          end
        if (k + 64 * n + n < e_end)
          chk(bad_i < 0, vld ? "R5" : "R8", {tag, " half-bit level"},
              (bad_i < 0) ? 0 : int'(line_log[bad_i]), (bad_i < 0) ? 0 : int'(e[bad_j]));
        if (bad_i >= 0) $display("  (half-bit %0d, preamble kind %0d, R3/R4)", bad_j, kind);
        prev = e[63];
        last_k = kind;
        if (kind == 0) fidx = 0;
        else if (kind == 1) fidx = (fidx == FR - 1) ? 0 : fidx + 1;
      end
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; enable = 1'b1; ratio_sel = 2'd0;
    repeat (3) @(negedge clk);
    #1;
    chk(line_out == 1'b0, "R1", "line in reset", int'(line_out), 0);
    chk(underflow == 1'b0, "R1", "underflow in reset", int'(underflow), 0);
    @(negedge clk); enable = 1'b0; #1;
    chk(s_ready == 1'b0, "R1", "ready while disabled", int'(s_ready), 0);
    rst_n = 1'b1;
  endtask

  task automatic t_ratio(input logic [1:0] sel, input int n, input string tag);
    int s, tk, iv, bf;
    clear_src();
    add({28'h0000001, 4'h1}, 1'b0);   // block start, 27 zeros flips level
    add({28'hFFFFFFF, 4'h3}, 1'b0);
    add({28'hA5A5A5A, 4'h2}, 1'b0);
    add({28'h0000000, 4'h3}, 1'b0);
    add({28'h8000001, 4'h2}, 1'b0);
    add({28'h1234567, 4'h3}, 1'b0);
    run(sel, 64 * n * 6 + 2 * n, s);
    check_stream(s, s + 64 * n * 6 + 2 * n, n, tag, tk, iv, bf);
    chk(tk == 6, "R7", {tag, " subframes taken once"}, tk, 6);
    chk(iv > 0, "R4", {tag, " inverted preamble seen"}, iv, 1);
  endtask

  task automatic t_underflow();
    int s, tk, iv, bf;
    clear_src();
    add({28'h0F0F0F1, 4'h1}, 1'b0);
    add({28'h1111111, 4'h3}, 1'b0);
    add({28'h2222222, 4'h2}, 1'b0);
    add(32'd0, 1'b1);                  // fill, right pattern expected (R9)
    add({28'h3333333, 4'h2}, 1'b0);
    add({28'h4444444, 4'h3}, 1'b0);
    add(32'd0, 1'b1);                  // fill, left pattern
    add(32'd0, 1'b1);                  // fill, right pattern
    add(32'd0, 1'b1);                  // fill, block start (block of FR frames done)
    run(2'd0, 64 * 10 + 2, s);
    check_stream(s, s + 64 * 10 + 2, 1, "underflow", tk, iv, bf);
    chk(tk == 5, "R7", "underflow run takes", tk, 5);
    chk(bf > 0, "R9", "block-start filler seen", bf, 1);
  endtask

  task automatic t_disable();
    int d;
    clear_src();
    for (int i = 0; i < 8; i++) add({28'hFFFFFFF, 4'h2}, 1'b0);
    @(negedge clk); rst_n = 1'b1; ratio_sel = 2'd1; src_pos = 0; hs_seen = 1'b0;
    enable = 1'b1;
    repeat (301) @(negedge clk);
    enable = 1'b0; d = cyc;
    repeat (6) @(negedge clk);
    chk(rdy_log[d] == 1'b0, "R1", "ready when disabled", int'(rdy_log[d]), 0);
    chk(line_log[d+1] == 1'b0, "R1", "line after disable", int'(line_log[d+1]), 0);
    chk(line_log[d+4] == 1'b0 && uf_log[d+4] == 1'b0, "R1", "held low", int'(line_log[d+4]), 0);
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_ratio(2'd0, 1, "ratio0");
        t_ratio(2'd1, 2, "ratio1");
        t_ratio(2'd2, 4, "ratio2");
        t_ratio(2'd3, 4, "ratio3");
        t_underflow();
        t_disable();
      end
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "WDOG", "watchdog expired", 1, 0);
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule